// File: doc/BRIEF.md
# Vertical Three-Tap Video Lowpass

This block smooths a raster video stream down each column. Pixels arrive one per clock with a valid strobe, a start-of-line flag and a start-of-frame flag. Each pixel carries three 8-bit channels. In luma/chroma mode, channel 0 is luma and channels 1 and 2 are chroma. In RGB mode, the three channels are three colour components. The block stores the two preceding lines. It then applies a symmetric three-tap kernel to the line above, the centre line and the line below.

Luma and chroma each have a 2-bit kernel code:

| Code | Kernel (sixteenths: above, centre, below) |
|------|-------------------------------------------|
| 00 | 0, 16, 0 (pass-through) |
| 01 | 4, 8, 4 |
| 10 | 3, 10, 3 |
| 11 | reserved, treated as pass-through |

In RGB mode, the luma code drives all three channels.

The output for a row needs the row beneath it. For this reason, output row r is produced while input row r+1 arrives, one clock behind each input pixel. The last row of a frame is produced while the first line of the next frame arrives.

The controller is a line-position state machine with four states:

- **LN_IDLE**: after reset, no frame has started.
- **LN_TOP**: the first line of a frame is arriving.
- **LN_SECOND**: the second line is arriving.
- **LN_BODY**: any later line is arriving.

State transitions happen only on a valid start-of-line pixel:

| Transition | From | To | Condition |
|------------|------|----|-----------|
| frame start | any state | LN_TOP | start-of-frame is also set |
| row advance | LN_TOP | LN_SECOND | no start-of-frame |
| body entry | LN_SECOND | LN_BODY | no start-of-frame |
| body hold | LN_BODY | LN_BODY | no start-of-frame |
| idle hold | LN_IDLE | LN_IDLE | no start-of-frame |

Top module: `vcol_lowpass`

## Requirements
- R1: After reset, out_valid, out_sol and out_sof are all 0.
- R2: Output timing follows the input, one clock behind.
  - Output row r of a frame appears one clock after each valid pixel of input row r+1, at the same column.
  - out_sol marks the first pixel of each emitted row.
  - out_sof marks the first pixel of row 0, which is emitted during input row 1.
- R3: Code 00 passes the centre line unchanged.
- R4: Code 01 gives (4·above + 8·centre + 4·below + 8) >> 4.
- R5: Code 10 gives (3·above + 10·centre + 3·below + 8) >> 4.
- R6: Code 11 behaves as code 00.
- R7: When cfg_rgb is 0, the channel assignment is as follows.
  - Channel 0 (bits 7:0) uses the luma code.
  - Channels 1 (bits 15:8) and 2 (bits 23:16) use the chroma code.
- R8: When cfg_rgb is 1, all three channels use the luma code, and the chroma code has no effect on the output.
- R9: Missing neighbour lines are replaced by the row itself (edge replication).
  - Row 0 uses itself as the line above.
  - The last row of a frame uses itself as the line below. That row is emitted during the first line of the next frame.
  - Nothing is emitted during the first line after reset.
- R10: The codes and the mode are sampled on the valid start-of-frame pixel. They apply to every row of that frame, including its last row. Changes in the middle of a frame have no effect until the next start-of-frame.
- R11: out_valid is 1 only one clock after a valid input pixel that produces an output. Input gaps produce output gaps.
- R12: Every output channel lies between the minimum and maximum of its three taps, so it never exceeds 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_code_luma | input | 2 | Kernel code for luma (all channels in RGB mode) |
| cfg_code_chroma | input | 2 | Kernel code for chroma channels |
| cfg_rgb | input | 1 | RGB mode: luma code governs all channels |
| in_valid | input | 1 | Input pixel valid |
| in_sol | input | 1 | First pixel of a line |
| in_sof | input | 1 | First pixel of a frame (set together with in_sol) |
| in_pix | input | 24 | Three 8-bit channels, channel 0 in bits 7:0 |
| out_valid | output | 1 | Output pixel valid |
| out_sol | output | 1 | First pixel of an emitted row |
| out_sof | output | 1 | First pixel of an emitted frame |
| out_pix | output | 24 | Filtered channels, same layout as in_pix |

## Verification
The assertions check several properties on every cycle:
- The output strobe always follows an input strobe.
- A frame marker always sits on a line marker.
- The active codes move only on a line start.
- Pass-through codes reproduce the centre tap.
- Every filtered value stays within the range of its taps.

Other properties can only be shown by the bench's scenarios, which compare against a line-based reference model. These include:
- The exact kernel arithmetic and its rounding.
- The luma/chroma channel routing in both modes.
- Edge replication at the top row, and at the bottom row emitted during the next frame.
- The rule that mid-frame code changes wait for the next frame start.

// File: rtl/vcol_pkg.sv
package vcol_pkg;

    localparam int WFRAC = 4;

    typedef enum logic [1:0] {
        LN_IDLE,
        LN_TOP,
        LN_SECOND,
        LN_BODY
    } vcol_line_e;

    typedef struct packed {
        logic [4:0] k_up;
        logic [4:0] k_mid;
        logic [4:0] k_dn;
    } vcol_taps_t;

    function automatic vcol_taps_t vcol_taps(input logic [1:0] code);
        vcol_taps_t t;
        case (code)
            2'b01:   t = '{k_up: 5'd4, k_mid: 5'd8,  k_dn: 5'd4};
            2'b10:   t = '{k_up: 5'd3, k_mid: 5'd10, k_dn: 5'd3};
            default: t = '{k_up: 5'd0, k_mid: 5'd16, k_dn: 5'd0};
        endcase
        return t;
    endfunction

endpackage

// File: rtl/vcol_linestore.sv
module vcol_linestore #(
    parameter int DEPTH = 1024,
    parameter int PW    = 24,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [PW-1:0] din,
    output logic [PW-1:0] prev1,
    output logic [PW-1:0] prev2
);
    logic [PW-1:0] line1 [DEPTH];
    logic [PW-1:0] line2 [DEPTH];

    assign prev1 = line1[addr];
    assign prev2 = line2[addr];

    always_ff @(posedge clk) begin
        if (we) begin
            line2[addr] <= line1[addr];
            line1[addr] <= din;
        end
    end
endmodule

// File: rtl/vcol_tap3.sv
module vcol_tap3
    import vcol_pkg::*;
#(
    parameter int PW  = 8,
    localparam int SW = PW + 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [1:0]    code,
    input  logic [PW-1:0] up,
    input  logic [PW-1:0] mid,
    input  logic [PW-1:0] dn,
    output logic [PW-1:0] q
);
    vcol_taps_t    t;
    logic [SW-1:0] acc;
    logic [PW-1:0] hi, lo;

    always_comb begin
        t   = vcol_taps(code);
        acc = SW'(up) * SW'(t.k_up) + SW'(mid) * SW'(t.k_mid)
            + SW'(dn) * SW'(t.k_dn) + (SW'(1) << (WFRAC - 1));
        hi  = (up > mid) ? up : mid;
        hi  = (dn > hi) ? dn : hi;
        lo  = (up < mid) ? up : mid;
        lo  = (dn < lo) ? dn : lo;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= PW'(acc >> WFRAC);
    end

    // R3 R6
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (code == 2'b00 || code == 2'b11)) |=> (q == $past(mid)));

    // R12
    in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (q <= $past(hi) && q >= $past(lo)));
endmodule

// File: rtl/vcol_lowpass.sv
module vcol_lowpass
    import vcol_pkg::*;
#(
    parameter int PW    = 8,
    parameter int NCH   = 3,
    parameter int DEPTH = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_code_luma,
    input  logic [1:0]       cfg_code_chroma,
    input  logic             cfg_rgb,
    input  logic             in_valid,
    input  logic             in_sol,
    input  logic             in_sof,
    input  logic [PW*NCH-1:0] in_pix,
    output logic             out_valid,
    output logic             out_sol,
    output logic             out_sof,
    output logic [PW*NCH-1:0] out_pix
);
    localparam int DW = PW * NCH;
    localparam int AW = $clog2(DEPTH);

    vcol_line_e    state, nxt;
    logic [AW-1:0] col, idx;
    logic          have_prev;
    logic [1:0]    pend_y, pend_c, act_y, act_c, use_y, use_c;
    logic          pend_rgb, act_rgb, use_rgb;
    logic          emit, take_act;
    logic [DW-1:0] prev1, prev2, tap_up, tap_dn;

    // line-position state machine: next state
    always_comb begin
        nxt = state;
        if (in_valid && in_sol) begin
            if (in_sof) nxt = LN_TOP;
            else begin
                unique case (state)
                    LN_IDLE:   nxt = LN_IDLE;
                    LN_TOP:    nxt = LN_SECOND;
                    LN_SECOND: nxt = LN_BODY;
                    LN_BODY:   nxt = LN_BODY;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= LN_IDLE;
        else        state <= nxt;
    end

    // per-pixel decode against the line the current pixel belongs to
    always_comb begin
        idx      = in_sol ? '0 : col;
        emit     = in_valid && ((nxt == LN_TOP && have_prev)
                                || nxt == LN_SECOND || nxt == LN_BODY);
        take_act = in_valid && in_sol && (nxt == LN_SECOND);
        use_y    = take_act ? pend_y   : act_y;
        use_c    = take_act ? pend_c   : act_c;
        use_rgb  = take_act ? pend_rgb : act_rgb;
        tap_up   = (nxt == LN_SECOND) ? prev1 : prev2;
        tap_dn   = (nxt == LN_TOP)    ? prev1 : in_pix;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col       <= '0;
            have_prev <= 1'b0;
            pend_y    <= 2'b00;
            pend_c    <= 2'b00;
            pend_rgb  <= 1'b0;
            act_y     <= 2'b00;
            act_c     <= 2'b00;
            act_rgb   <= 1'b0;
        end else begin
            if (in_valid) col <= idx + 1'b1;
            if (in_valid && in_sof && in_sol) begin
                pend_y   <= cfg_code_luma;
                pend_c   <= cfg_code_chroma;
                pend_rgb <= cfg_rgb;
            end
            if (take_act) begin
                act_y     <= pend_y;
                act_c     <= pend_c;
                act_rgb   <= pend_rgb;
                have_prev <= 1'b1;
            end
        end
    end

    // output markers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
            out_sof   <= 1'b0;
        end else begin
            out_valid <= emit;
            out_sol   <= emit && in_sol;
            out_sof   <= emit && in_sol && (nxt == LN_SECOND);
        end
    end

    vcol_linestore #(.DEPTH(DEPTH), .PW(DW)) store_i (
        .clk   (clk),
        .we    (in_valid),
        .addr  (idx),
        .din   (in_pix),
        .prev1 (prev1),
        .prev2 (prev2)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [1:0] ch_code;
        assign ch_code = (g == 0 || use_rgb) ? use_y : use_c;
        vcol_tap3 #(.PW(PW)) tap_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (emit),
            .code  (ch_code),
            .up    (tap_up[g*PW +: PW]),
            .mid   (prev1[g*PW +: PW]),
            .dn    (tap_dn[g*PW +: PW]),
            .q     (out_pix[g*PW +: PW])
        );
    end

    // R2
    sof_on_sol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_sol && out_valid));

    // R11
    valid_follows_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R10
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(act_y) && $stable(act_c) && $stable(act_rgb)) |-> $past(in_valid && in_sol));
endmodule

// File: tb/vcol_lowpass_tb_top.sv
module vcol_lowpass_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_code_luma, cfg_code_chroma;
    logic        cfg_rgb;
    logic        in_valid, in_sol, in_sof;
    logic [23:0] in_pix;
    logic        out_valid, out_sol, out_sof;
    logic [23:0] out_pix;

    always #10 clk = ~clk;

    vcol_lowpass dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_code_luma(cfg_code_luma), .cfg_code_chroma(cfg_code_chroma), .cfg_rgb(cfg_rgb),
        .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof), .in_pix(in_pix),
        .out_valid(out_valid), .out_sol(out_sol), .out_sof(out_sof), .out_pix(out_pix)
    );

    int    n_chk = 0, n_bad = 0;
    int    l1 [1024];
    int    l2 [1024];
    int    brow = -1, bcol = 0;
    bit    have_prev = 0;
    int    pend_y = 0, pend_c = 0, act_y = 0, act_c = 0;
    bit    pend_rgb = 0, act_rgb = 0;
    bit    e_valid = 0, e_sol = 0, e_sof = 0;
    int    e_pix [3];
    string tag = "R1";

    function automatic int wt(int code, int pos);
        if (code == 1) return (pos == 1) ? 8 : 4;
        if (code == 2) return (pos == 1) ? 10 : 3;
        return (pos == 1) ? 16 : 0;
    endfunction

    function automatic int filt(int code, int a, int c, int b);
        return (wt(code, 0) * a + wt(code, 1) * c + wt(code, 2) * b + 8) / 16;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(bit v, bit sol, bit sof, logic [23:0] p);
        @(negedge clk);
        check(tag, "out_valid", int'(out_valid), int'(e_valid));
        if (e_valid) begin
            check(tag, "out_sol", int'(out_sol), int'(e_sol));
            check(tag, "out_sof", int'(out_sof), int'(e_sof));
            for (int k = 0; k < 3; k++)
                check(tag, $sformatf("ch%0d col%0d", k, bcol - 1), int'(out_pix[8*k +: 8]), e_pix[k]);
        end
        e_valid = 0; e_sol = 0; e_sof = 0;
        if (v) begin
            if (sol) bcol = 0;
            if (sof) begin
                brow = 0; pend_y = cfg_code_luma; pend_c = cfg_code_chroma; pend_rgb = cfg_rgb;
            end else if (sol && brow >= 0) brow++;
            if (sol && brow == 1) begin
                act_y = pend_y; act_c = pend_c; act_rgb = pend_rgb; have_prev = 1;
            end
            e_valid = (brow == 0 && have_prev) || brow >= 1;
            e_sol = e_valid && sol;
            e_sof = e_valid && sol && brow == 1;
            for (int k = 0; k < 3; k++) begin
                int a, c, b, code, pin;
                pin  = int'(p[8*k +: 8]);
                c    = (l1[bcol] >> (8 * k)) & 255;
                a    = (brow == 1) ? c : ((l2[bcol] >> (8 * k)) & 255);
                b    = (brow == 0) ? c : pin;
                code = (k == 0 || act_rgb) ? act_y : act_c;
                e_pix[k] = filt(code, a, c, b);
            end
            l2[bcol] = l1[bcol];
            l1[bcol] = int'(p);
            bcol++;
        end
        in_valid = v; in_sol = sol; in_sof = sof; in_pix = p;
    endtask

    // style 0: random, 1: rows alternate full/zero, 2: ramp
    task automatic send_frame(int lines, int width, int style, bit mid_change);
        for (int r = 0; r < lines; r++) begin
            if (mid_change && r == 2) begin
                cfg_code_luma = ~cfg_code_luma; cfg_code_chroma = ~cfg_code_chroma; cfg_rgb = ~cfg_rgb;
            end
            for (int x = 0; x < width; x++) begin
                logic [23:0] p;
                if (style == 0)      p = 24'($urandom);
                else if (style == 1) p = (r % 2 == 0) ? 24'hFFFFFF : 24'h000000;
                else                 p = {8'(x * 30), 8'(r * 40 + x), 8'(255 - r * 50)};
                step(1'b1, x == 0, r == 0 && x == 0, p);
                if (x % 5 == 3) step(1'b0, 1'b0, 1'b0, 24'h0);
            end
            step(1'b0, 1'b0, 1'b0, 24'h0);
            step(1'b0, 1'b0, 1'b0, 24'h0);
        end
    endtask

    initial begin
        #4000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hung expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin l1[i] = 0; l2[i] = 0; end
        rst_n = 0; in_valid = 0; in_sol = 0; in_sof = 0; in_pix = '0;
        cfg_code_luma = 2'b00; cfg_code_chroma = 2'b00; cfg_rgb = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "out_sol", int'(out_sol), 0);
        check("R1", "out_sof", int'(out_sof), 0);

        // YC mode: luma 01, chroma 10; first line after reset emits nothing (R9)
        tag = "R2,R4,R5,R7,R9,R11";
        cfg_code_luma = 2'b01; cfg_code_chroma = 2'b10; cfg_rgb = 1'b0;
        send_frame(5, 12, 0, 1'b0);

        // RGB mode with chroma code 11 ignored, mid-frame changes ignored (R8, R10)
        tag = "R8,R10,R4,R9";
        cfg_code_luma = 2'b01; cfg_code_chroma = 2'b11; cfg_rgb = 1'b1;
        send_frame(6, 10, 0, 1'b1);

        // extremes with code 10 luma and 00 chroma (R12, R3)
        tag = "R12,R5,R3,R10";
        cfg_code_luma = 2'b10; cfg_code_chroma = 2'b00; cfg_rgb = 1'b0;
        send_frame(4, 9, 1, 1'b0);

        // reserved code on luma, kernel 01 on chroma (R6)
        tag = "R6,R4,R7";
        cfg_code_luma = 2'b11; cfg_code_chroma = 2'b01; cfg_rgb = 1'b0;
        send_frame(3, 16, 2, 1'b0);

        // RGB mode, code 10 everywhere, then a flush frame for the bottom edge (R9)
        tag = "R8,R5,R9,R2";
        cfg_code_luma = 2'b10; cfg_code_chroma = 2'b00; cfg_rgb = 1'b1;
        send_frame(4, 8, 0, 1'b0);
        tag = "R9,R3";
        cfg_code_luma = 2'b00; cfg_code_chroma = 2'b00; cfg_rgb = 1'b0;
        send_frame(2, 8, 2, 1'b0);
        step(1'b0, 1'b0, 1'b0, 24'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule